// File: doc/BRIEF.md
# SPDIF Channel Status Capture Unit

This block follows an IEC 60958 biphase decoder and watches the stream of decoded subframes it produces. Each subframe brings a preamble type and the channel-status bit carried in it. The block rebuilds the first 40 channel-status bits of every 192-frame block, keeping the left and right channels apart. It publishes each channel's 40 bits as a register that changes all at once, and only when a block has been received in full.

From the left channel's captured word the block decodes four fields: the non-audio (non-PCM) flag, the pre-emphasis code, the sample-rate code and the clock-accuracy code. From those fields and the receiver's lock flag it derives two control outputs. One is a mute request for the audio outputs. The other is a de-emphasis enable for the path to the DAC.

The unit works on subframe events and not on the audio rate, so streams from 28 to 96 kHz need nothing special. Losing lock wipes every captured value. The mute request then stays up until lock returns.

The subframe input is a valid/ready stream. The block never applies back-pressure: `sf_ready` is always high, and a subframe counts as accepted in any cycle where `sf_valid` is high.

Top module: `spdif_cs_capture`

## Requirements
- R1: `sf_ready` is 1 in every cycle. A subframe is accepted on each rising clock edge at which `sf_valid` is 1.
- R2: The preamble code `sf_pre` is 2'b00 for block start (left), 2'b01 for right and 2'b10 for left. Code 2'b11 is ignored. A left-channel status bit with index n comes from the n-th left subframe after the block start, where the block-start subframe itself is index 0. The right-channel bit with index n comes from the right subframe of the same frame.
- R3: Bit n of `cs_left` and `cs_right` holds channel-status bit n. Both registers update together, one clock after the right subframe of frame 39 is accepted, and not earlier.
- R4: Subframes accepted after lock rises but before the first block-start subframe are ignored. So are status bits from frames 40 and above. Between two complete blocks, the captured registers hold their value.
- R5: While `lock` is 0, from the next clock edge on: `cs_left`, `cs_right`, `cs_valid`, all decoded fields, `deemph_en` and `locked` are 0, and `mute_req` is 1. A block cut short by loss of lock is discarded. After lock returns, nothing updates until a new block completes in full.
- R6: After reset, the outputs are in the same state as in R5.
- R7: The decoded fields come from `cs_left`, as follows.
  - `non_pcm` is bit 1.
  - `emph` is {bit 5, bit 4, bit 3}.
  - `fs_code` is bits 27 down to 24, with bit 24 as the LSB.
  - `clk_acc` is {bit 29, bit 28}.
- R8: `deemph_en` is 1 only when all three of these hold: `cs_valid` is 1, `non_pcm` is 0, and `emph` equals 3'b001 (bit 3 set, bits 4 and 5 clear).
- R9: `cs_valid` rises one clock after the first block completes since lock was gained. It stays high while lock holds.
- R10: `locked` follows `lock` one clock later. `mute_req` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock | input | 1 | Lock flag from clock recovery |
| sf_valid | input | 1 | Subframe strobe |
| sf_ready | output | 1 | Always 1; no back-pressure |
| sf_pre | input | 2 | Preamble code (see R2) |
| sf_cs | input | 1 | Channel-status bit of the subframe |
| locked | output | 1 | Registered lock state |
| mute_req | output | 1 | Mute request to the audio outputs |
| cs_valid | output | 1 | A complete block has been captured |
| cs_left | output | 40 | Captured left channel-status bits |
| cs_right | output | 40 | Captured right channel-status bits |
| non_pcm | output | 1 | Non-audio payload flag |
| emph | output | 3 | Pre-emphasis code |
| fs_code | output | 4 | Sample-rate code |
| clk_acc | output | 2 | Clock accuracy code |
| deemph_en | output | 1 | De-emphasis enable for the DAC path |

## Verification
Every result has a latency of one clock. The capture registers, `cs_valid` and the decoded fields change at the edge that accepts the right subframe of frame 39. `locked`, `mute_req` and the cleared state follow `lock` by one edge. The bench drives inputs on the falling edge and holds each subframe for one cycle, so the accepting rising edge falls in between. It samples at the next falling edge. Before sending the final right subframe, the bench also samples once to confirm that nothing has changed early.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;
  typedef enum logic [1:0] {
    PRE_BLK  = 2'b00,
    PRE_RGT  = 2'b01,
    PRE_LFT  = 2'b10,
    PRE_NONE = 2'b11
  } pre_e;

  localparam int CS_BITS_DEF  = 40;
  localparam int FRAMES_DEF   = 192;
  localparam int POS_NONPCM   = 1;
  localparam int POS_EMPH_LO  = 3;
  localparam int EMPH_W       = 3;
  localparam int POS_FS_LO    = 24;
  localparam int FS_W         = 4;
  localparam int POS_ACC_LO   = 28;
  localparam int ACC_W        = 2;
  localparam logic [EMPH_W-1:0] EMPH_ON = 3'b001;
endpackage

// File: rtl/spdif_cs_tracker.sv
module spdif_cs_tracker
  import spdif_cs_pkg::*;
#(
  parameter int CS_BITS = CS_BITS_DEF,
  parameter int FRAMES  = FRAMES_DEF,
  localparam int IDX_W  = $clog2(FRAMES),
  localparam int POS_W  = $clog2(CS_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             hs,
  input  logic [1:0]       pre,
  output logic             take_l,
  output logic             take_r,
  output logic [POS_W-1:0] pos_l,
  output logic [POS_W-1:0] pos_r,
  output logic             commit
);
  localparam logic [IDX_W:0]   LIMIT   = (IDX_W+1)'(CS_BITS);
  localparam logic [IDX_W:0]   LAST    = (IDX_W+1)'(CS_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx;
  logic             in_blk;
  logic [IDX_W:0]   idx_inc;
  logic [IDX_W:0]   idx_ext;

  always_comb begin
    idx_ext = {1'b0, idx};
    idx_inc = idx_ext + 1'b1;
    take_l  = hs && lock && ((pre == PRE_BLK) ||
              (pre == PRE_LFT && in_blk && idx_inc < LIMIT));
    pos_l   = (pre == PRE_BLK) ? '0 : idx_inc[POS_W-1:0];
    take_r  = hs && lock && (pre == PRE_RGT) && in_blk && (idx_ext < LIMIT);
    pos_r   = idx_ext[POS_W-1:0];
    commit  = take_r && (idx_ext == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      in_blk <= 1'b0;
    end else if (!lock) begin
      idx    <= '0;
      in_blk <= 1'b0;
    end else if (hs) begin
      if (pre == PRE_BLK) begin
        idx    <= '0;
        in_blk <= 1'b1;
      end else if (pre == PRE_LFT && in_blk && idx != IDX_MAX) begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spdif_cs_channel.sv
module spdif_cs_channel
  import spdif_cs_pkg::*;
#(
  parameter int CS_BITS = CS_BITS_DEF,
  localparam int POS_W  = $clog2(CS_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock,
  input  logic               take,
  input  logic [POS_W-1:0]   pos,
  input  logic               bit_in,
  input  logic               commit,
  output logic [CS_BITS-1:0] cap
);
  logic [CS_BITS-1:0] shadow;
  logic [CS_BITS-1:0] shadow_nxt;

  always_comb begin
    shadow_nxt = shadow;
    if (take) shadow_nxt[pos] = bit_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      cap    <= '0;
    end else if (!lock) begin
      shadow <= '0;
      cap    <= '0;
    end else begin
      shadow <= shadow_nxt;
      if (commit) cap <= shadow_nxt;
    end
  end
endmodule

// File: rtl/spdif_cs_fields.sv
module spdif_cs_fields
  import spdif_cs_pkg::*;
(
  input  logic              valid,
  input  logic              np_bit,
  input  logic [EMPH_W-1:0] emph_bits,
  input  logic [FS_W-1:0]   fs_bits,
  input  logic [ACC_W-1:0]  acc_bits,
  output logic              non_pcm,
  output logic [EMPH_W-1:0] emph,
  output logic [FS_W-1:0]   fs_code,
  output logic [ACC_W-1:0]  clk_acc,
  output logic              deemph_en
);
  always_comb begin
    non_pcm   = valid & np_bit;
    emph      = valid ? emph_bits : '0;
    fs_code   = valid ? fs_bits : '0;
    clk_acc   = valid ? acc_bits : '0;
    deemph_en = valid && !np_bit && (emph_bits == EMPH_ON);
  end
endmodule

// File: rtl/spdif_cs_capture.sv
module spdif_cs_capture
  import spdif_cs_pkg::*;
#(
  parameter int CS_BITS = CS_BITS_DEF,
  parameter int FRAMES  = FRAMES_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock,
  input  logic               sf_valid,
  output logic               sf_ready,
  input  logic [1:0]         sf_pre,
  input  logic               sf_cs,
  output logic               locked,
  output logic               mute_req,
  output logic               cs_valid,
  output logic [CS_BITS-1:0] cs_left,
  output logic [CS_BITS-1:0] cs_right,
  output logic               non_pcm,
  output logic [EMPH_W-1:0]  emph,
  output logic [FS_W-1:0]    fs_code,
  output logic [ACC_W-1:0]   clk_acc,
  output logic               deemph_en
);
  localparam int POS_W = $clog2(CS_BITS);
  localparam int NCH   = 2;

  logic             hs;
  logic             commit;
  logic             take [NCH];
  logic [POS_W-1:0] pos  [NCH];
  logic [CS_BITS-1:0] cap [NCH];
  logic             lock_q;
  logic             valid_q;

  assign sf_ready = 1'b1;
  assign hs       = sf_valid & sf_ready;

  spdif_cs_tracker #(.CS_BITS(CS_BITS), .FRAMES(FRAMES)) u_trk (
    .clk(clk), .rst_n(rst_n), .lock(lock), .hs(hs), .pre(sf_pre),
    .take_l(take[0]), .take_r(take[1]), .pos_l(pos[0]), .pos_r(pos[1]),
    .commit(commit)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    spdif_cs_channel #(.CS_BITS(CS_BITS)) u_ch (
      .clk(clk), .rst_n(rst_n), .lock(lock), .take(take[c]), .pos(pos[c]),
      .bit_in(sf_cs), .commit(commit), .cap(cap[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      lock_q <= lock;
      if (!lock)       valid_q <= 1'b0;
      else if (commit) valid_q <= 1'b1;
    end
  end

  assign cs_left  = cap[0];
  assign cs_right = cap[1];
  assign locked   = lock_q;
  assign mute_req = ~lock_q;
  assign cs_valid = valid_q;

  spdif_cs_fields u_fld (
    .valid(valid_q),
    .np_bit(cap[0][POS_NONPCM]),
    .emph_bits(cap[0][POS_EMPH_LO +: EMPH_W]),
    .fs_bits(cap[0][POS_FS_LO +: FS_W]),
    .acc_bits(cap[0][POS_ACC_LO +: ACC_W]),
    .non_pcm(non_pcm), .emph(emph), .fs_code(fs_code), .clk_acc(clk_acc),
    .deemph_en(deemph_en)
  );
endmodule

// File: rtl/spdif_cs_capture_chk.sv
module spdif_cs_capture_chk #(
  parameter int CS_BITS = 40
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lock,
  input logic               sf_valid,
  input logic [1:0]         sf_pre,
  input logic               locked,
  input logic               mute_req,
  input logic               cs_valid,
  input logic [CS_BITS-1:0] cs_left,
  input logic [CS_BITS-1:0] cs_right,
  input logic               non_pcm,
  input logic [2:0]         emph,
  input logic               deemph_en
);
  p_unlock_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> (mute_req && !locked && !cs_valid && cs_left == '0 && cs_right == '0));

  p_update_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !$stable(cs_right)) |-> $past(sf_valid && sf_pre == 2'b01 && lock));

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_valid) |-> $past(sf_valid && sf_pre == 2'b01 && lock));

  p_deemph_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    deemph_en |-> (cs_valid && !non_pcm && emph == 3'b001));
endmodule

bind spdif_cs_capture spdif_cs_capture_chk #(.CS_BITS(CS_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock(lock), .sf_valid(sf_valid), .sf_pre(sf_pre),
  .locked(locked), .mute_req(mute_req), .cs_valid(cs_valid),
  .cs_left(cs_left), .cs_right(cs_right), .non_pcm(non_pcm), .emph(emph),
  .deemph_en(deemph_en)
);

// File: tb/sim_spdif_cs_capture.sv
module sim_spdif_cs_capture;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, lock = 1'b0, sf_valid = 1'b0, sf_cs = 1'b0;
  logic [1:0] sf_pre = 2'b00;
  logic sf_ready, locked, mute_req, cs_valid, non_pcm, deemph_en;
  logic [39:0] cs_left, cs_right;
  logic [2:0] emph;
  logic [3:0] fs_code;
  logic [1:0] clk_acc;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  spdif_cs_capture u0 (
    .clk(clk), .rst_n(rst_n), .lock(lock), .sf_valid(sf_valid), .sf_ready(sf_ready),
    .sf_pre(sf_pre), .sf_cs(sf_cs), .locked(locked), .mute_req(mute_req),
    .cs_valid(cs_valid), .cs_left(cs_left), .cs_right(cs_right), .non_pcm(non_pcm),
    .emph(emph), .fs_code(fs_code), .clk_acc(clk_acc), .deemph_en(deemph_en)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_sf(input logic [1:0] p, input logic b);
    @(negedge clk);
    sf_valid = 1'b1; sf_pre = p; sf_cs = b;
    @(negedge clk);
    sf_valid = 1'b0;
  endtask

  // frames first..last-1 of a block; frame 0 uses the block-start code
  task automatic send_frames(input logic [39:0] l, input logic [39:0] r, input int first, input int last);
    for (int f = first; f < last; f++) begin
      send_sf(f == 0 ? 2'b00 : 2'b10, f < 40 ? l[f] : f[0]);
      send_sf(2'b01, f < 40 ? r[f] : ~f[0]);
    end
  endtask

  // full block with an early-update check before the last right subframe
  task automatic full_block(input logic [39:0] l, input logic [39:0] r, input string tag);
    logic [39:0] prev_l = cs_left;
    logic pv = cs_valid;
    send_frames(l, r, 0, 39);
    send_sf(2'b10, l[39]);
    chk(cs_left == prev_l && cs_valid == pv, {tag, " R3 no early update"}, cs_left, prev_l);
    send_sf(2'b01, r[39]);
    chk(cs_left == l, {tag, " R3 left"}, cs_left, l);
    chk(cs_right == r, {tag, " R3 right"}, cs_right, r);
    chk(cs_valid == 1'b1, {tag, " R9 valid"}, cs_valid, 1);
  endtask

  function automatic logic [39:0] mk(input logic np, input logic [2:0] e, input logic [3:0] fs,
                                     input logic [1:0] acc, input logic [39:0] fill);
    logic [39:0] v = fill;
    v[1] = np; v[5:3] = e; v[27:24] = fs; v[29:28] = acc;
    return v;
  endfunction

  task automatic chk_fields(input logic [39:0] l, input logic exp_de, input string tag);
    chk(non_pcm == l[1], {tag, " R7 non_pcm"}, non_pcm, l[1]);
    chk(emph == {l[5], l[4], l[3]}, {tag, " R7 emph"}, emph, {l[5], l[4], l[3]});
    chk(fs_code == l[27:24], {tag, " R7 fs_code"}, fs_code, l[27:24]);
    chk(clk_acc == {l[29], l[28]}, {tag, " R7 clk_acc"}, clk_acc, {l[29], l[28]});
    chk(deemph_en == exp_de, {tag, " R8 deemph"}, deemph_en, exp_de);
  endtask

  task automatic chk_cleared(input string tag);
    chk(mute_req && !locked, {tag, " R10 mute/locked"}, {mute_req, locked}, 2'b10);
    chk(cs_left == 0 && cs_right == 0 && !cs_valid, {tag, " cleared regs"}, cs_left | cs_right, 0);
    chk(!non_pcm && emph == 0 && fs_code == 0 && clk_acc == 0 && !deemph_en,
        {tag, " cleared fields"}, {non_pcm, emph, fs_code, clk_acc, deemph_en}, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; lock = 1'b0;
    repeat (3) @(negedge clk);
    chk_cleared("R6 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_cleared("R6 after release");
  endtask

  task automatic t_lock_up;
    lock = 1'b1;
    @(negedge clk);
    chk(locked && !mute_req, "R10 lock up", {locked, mute_req}, 2'b10);
    chk(sf_ready == 1'b1, "R1 ready", sf_ready, 1);
    chk(!cs_valid, "R9 not valid before block", cs_valid, 0);
  endtask

  task automatic t_ignore_before_start;
    send_sf(2'b10, 1'b1); send_sf(2'b01, 1'b1); send_sf(2'b10, 1'b1);
    chk(cs_left == 0 && !cs_valid, "R4 pre-start ignored", cs_left, 0);
    full_block(mk(0, 3'b001, 4'b0010, 2'b01, 40'h5A_C3F0_0F96), 40'h12_3456_789A, "R2 first");
    chk_fields(mk(0, 3'b001, 4'b0010, 2'b01, 40'h5A_C3F0_0F96), 1'b1, "R7 audio emph");
  endtask

  task automatic t_fields;
    logic [39:0] a = mk(1, 3'b001, 4'b1101, 2'b10, 40'hFF_0000_FFFF);
    logic [39:0] b = mk(0, 3'b011, 4'b0011, 2'b11, 40'h00_FFFF_0000);
    full_block(a, ~a, "R8 nonpcm");
    chk_fields(a, 1'b0, "R8 nonpcm");
    full_block(b, 40'hA5A5_A5A5_A5, "R8 emph011");
    chk_fields(b, 1'b0, "R8 emph011");
  endtask

  task automatic t_extra_and_hold;
    logic [39:0] a = mk(0, 3'b000, 4'b0001, 2'b00, 40'hC3_3C69_9600);
    logic [39:0] r = 40'h0F_F00F_F0AA;
    send_frames(a, r, 0, 60);
    chk(cs_left == a, "R4 extra frames left", cs_left, a);
    chk(cs_right == r, "R4 extra frames right", cs_right, r);
    send_frames(~a, ~r, 0, 12);
    chk(cs_left == a && cs_right == r, "R4 hold on partial block", cs_left, a);
  endtask

  task automatic t_code3_and_gaps;
    logic [39:0] a = mk(0, 3'b001, 4'b1000, 2'b10, 40'h69_9669_0000);
    logic [39:0] r = 40'h33_CC33_CC33;
    send_frames(a, r, 0, 20);
    send_sf(2'b11, ~a[20]);
    repeat (3) @(negedge clk);
    send_frames(a, r, 20, 39);
    send_sf(2'b11, 1'b1);
    send_sf(2'b10, a[39]);
    send_sf(2'b01, r[39]);
    chk(cs_left == a && cs_right == r, "R2 code 2'b11 ignored", cs_left, a);
    chk(deemph_en == 1'b1, "R8 emph on", deemph_en, 1);
  endtask

  task automatic t_lock_loss;
    logic [39:0] a = mk(0, 3'b001, 4'b0110, 2'b01, 40'h11_2233_4455);
    send_frames(a, ~a, 0, 20);
    @(negedge clk); lock = 1'b0;
    @(negedge clk);
    chk_cleared("R5 lock loss");
    lock = 1'b1;
    @(negedge clk);
    send_frames(a, ~a, 20, 40);
    chk(cs_left == 0 && !cs_valid && !deemph_en, "R5 truncated block discarded", cs_left, 0);
    full_block(a, ~a, "R5 relock");
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_lock_up();
    t_ignore_before_start();
    t_fields();
    t_extra_and_hold();
    t_code3_and_gaps();
    t_lock_loss();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule